// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block schedules refresh cycles for dynamic memory banks. An interval counter starts from a programmed value and counts up to a fixed terminal value. Each time it reaches that value, the block raises a refresh request to the memory arbiter and reloads the counter. A larger programmed value therefore gives a shorter interval. The request stays up until the arbiter grants it. The counter does not stop while the request waits, so the refresh rate does not drift.

Once the grant is taken, a mode input selects the strobe pattern. For asynchronous DRAM banks the block drives a column-strobe-first refresh: the column strobe rises first, the row strobe follows after a programmable setup time, both stay asserted for a programmable hold time, and then both are released together. For SDRAM banks the block issues one auto-refresh command that lasts a single clock. The control word is written in one cycle and holds the interval value, an enable, a hold-time code and a setup-time code.

Top module: `mem_refresh_timer`

## Requirements
- R1: After reset, `ref_req`, `dram_cas`, `dram_ras` and `sdram_aref` are low. The stored interval value is 0 and refresh is disabled, so no request is raised until the control word is written.
- R2: With refresh enabled and interval value C (11 bits), the first request becomes visible 2049 − C clock edges after the write edge and then recurs every 2049 − C edges. C = 0 gives 2049 edges and C = 2047 gives 2 edges.
- R3: Every control-word write reloads the interval counter from the newly written value on the write edge, which restarts the interval.
- R4: While refresh is disabled no request is raised. A write that clears the enable also drops a pending request on that same edge.
- R5: A request stays high until an edge where `ref_gnt` is high while no strobe sequence is running. It is low after that edge.
- R6: The interval counter keeps running while a request waits for its grant, so the next request arrives on the original schedule.
- R7: In DRAM mode (`mem_sdram` = 0 at the grant edge), `dram_cas` is high after the grant edge. `dram_ras` rises S edges later, where setup code 0 gives S = 1 and code 1 gives S = 2.
- R8: In DRAM mode, `dram_cas` and `dram_ras` stay high together for H clocks, where hold codes 0, 1, 2, 3 and 4 give H = 1 to 5. After that, both fall on the same edge.
- R9: Hold codes 5, 6 and 7 are treated as code 4, which is 5 clocks.
- R10: In SDRAM mode (`mem_sdram` = 1 at the grant edge), `sdram_aref` is high for exactly one clock, starting after the grant edge. `dram_cas` and `dram_ras` stay low.
- R11: `dram_ras` is never high without `dram_cas`, and `sdram_aref` is never high together with `dram_cas`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-word write strobe, one cycle |
| cfg_count | input | 11 | Interval start value |
| cfg_en | input | 1 | Refresh enable |
| cfg_hold | input | 3 | Strobe hold-time code |
| cfg_setup | input | 1 | Column-to-row setup-time code |
| mem_sdram | input | 1 | 1 = SDRAM banks, 0 = DRAM banks |
| ref_gnt | input | 1 | Grant from the memory arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| dram_cas | output | 1 | Column strobe, active high |
| dram_ras | output | 1 | Row strobe, active high |
| sdram_aref | output | 1 | Auto-refresh command pulse |

## Verification
The checker watches the strobes on every cycle:
- the row strobe only inside the column strobe;
- no overlap between the auto-refresh pulse and the column strobe;
- a one-clock auto-refresh pulse;
- strobes that only start after a request meets a grant;
- a request that cannot vanish without a grant or a write;
- no request while refresh is disabled.

The exact interval length, the reload on rewrite, the setup and hold lengths for each code, and the schedule held while a grant is delayed depend on the programmed values. Only the bench's scenarios show those, by comparing event cycles against a queue of predicted events.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    localparam int HOLD_CODE_W  = 3;
    localparam int SETUP_CODE_W = 1;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_HOLD  = 2'd2,
        SQ_AREF  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/mrt_interval.sv
module mrt_interval #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] start_val,
    output logic             expire,
    output logic [CNT_W:0]   cnt_o
);
    localparam logic [CNT_W:0] TERM = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && (cnt_q == TERM);
        if (load) begin
            cnt_d = {1'b0, start_val};
        end else if (run) begin
            if (expire) begin
                cnt_d = {1'b0, start_val};
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/mrt_strobe_seq.sv
module mrt_strobe_seq
    import mrt_pkg::*;
#(
    parameter int HOLD_LIMIT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    sdram,
    input  logic [SETUP_CODE_W-1:0] setup_code,
    input  logic [HOLD_CODE_W-1:0]  hold_code,
    output logic                    idle,
    output logic                    cas,
    output logic                    ras,
    output logic                    aref
);
    localparam int TMR_W = $clog2(HOLD_LIMIT + 2);
    localparam logic [HOLD_CODE_W-1:0] HOLD_CAP = HOLD_CODE_W'(HOLD_LIMIT);

    typedef struct packed {
        seq_state_e       st;
        logic [TMR_W-1:0] tmr;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic [TMR_W-1:0] setup_len;
    logic [TMR_W-1:0] hold_len;

    always_comb begin
        setup_len = TMR_W'(setup_code);
        hold_len  = (hold_code > HOLD_CAP) ? TMR_W'(HOLD_CAP) : TMR_W'(hold_code);

        seq_d = seq_q;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    if (sdram) begin
                        seq_d.st = SQ_AREF;
                    end else begin
                        seq_d.st  = SQ_SETUP;
                        seq_d.tmr = setup_len;
                    end
                end
            end
            SQ_SETUP: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = SQ_HOLD;
                    seq_d.tmr = hold_len;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            SQ_HOLD: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st = SQ_IDLE;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            SQ_AREF: begin
                seq_d.st = SQ_IDLE;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, tmr: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle = (seq_q.st == SQ_IDLE);
    assign cas  = (seq_q.st == SQ_SETUP) || (seq_q.st == SQ_HOLD);
    assign ras  = (seq_q.st == SQ_HOLD);
    assign aref = (seq_q.st == SQ_AREF);
endmodule

// File: rtl/mem_refresh_timer.sv
module mem_refresh_timer
    import mrt_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int HOLD_LIMIT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [CNT_W-1:0]        cfg_count,
    input  logic                    cfg_en,
    input  logic [HOLD_CODE_W-1:0]  cfg_hold,
    input  logic [SETUP_CODE_W-1:0] cfg_setup,
    input  logic                    mem_sdram,
    input  logic                    ref_gnt,
    output logic                    ref_req,
    output logic                    dram_cas,
    output logic                    dram_ras,
    output logic                    sdram_aref
);
    typedef struct packed {
        logic [CNT_W-1:0]        count;
        logic                    en;
        logic [HOLD_CODE_W-1:0]  hold;
        logic [SETUP_CODE_W-1:0] setup;
        logic                    req;
    } ctl_reg_t;

    ctl_reg_t ctl_d, ctl_q;

    logic             expire;
    logic             seq_idle;
    logic             grant_take;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W:0]   cnt_w;

    always_comb begin
        start_val  = cfg_wr ? cfg_count : ctl_q.count;
        grant_take = ctl_q.req && ref_gnt && seq_idle;

        ctl_d = ctl_q;
        if (cfg_wr) begin
            ctl_d.count = cfg_count;
            ctl_d.en    = cfg_en;
            ctl_d.hold  = cfg_hold;
            ctl_d.setup = cfg_setup;
        end
        if (grant_take) begin
            ctl_d.req = 1'b0;
        end
        if (expire) begin
            ctl_d.req = 1'b1;
        end
        if (cfg_wr && !cfg_en) begin
            ctl_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mrt_interval #(
        .CNT_W (CNT_W)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.en),
        .load      (cfg_wr),
        .start_val (start_val),
        .expire    (expire),
        .cnt_o     (cnt_w)
    );

    mrt_strobe_seq #(
        .HOLD_LIMIT (HOLD_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (grant_take),
        .sdram      (mem_sdram),
        .setup_code (ctl_q.setup),
        .hold_code  (ctl_q.hold),
        .idle       (seq_idle),
        .cas        (dram_cas),
        .ras        (dram_ras),
        .aref       (sdram_aref)
    );

    assign ref_req = ctl_q.req;
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
    parameter int CNT_W = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_wr,
    input logic           ref_gnt,
    input logic           ref_req,
    input logic           dram_cas,
    input logic           dram_ras,
    input logic           sdram_aref,
    input logic           en_q,
    input logic [CNT_W:0] cnt
);
    localparam logic [CNT_W:0] TERM = {1'b1, {CNT_W{1'b0}}};

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TERM);

    p_no_req_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !ref_req);

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt && !cfg_wr) |=> ref_req);

    p_cas_after_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas) |-> $past(ref_req && ref_gnt));

    p_ras_after_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras) |-> $past(dram_cas));

    p_joint_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras) |-> !dram_cas);

    p_aref_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_aref |=> !sdram_aref);

    p_aref_after_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdram_aref) |-> $past(ref_req && ref_gnt));

    p_ras_in_cas_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras |-> dram_cas);

    p_aref_cas_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdram_aref, dram_cas}));
endmodule

bind mem_refresh_timer mrt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .dram_cas   (dram_cas),
    .dram_ras   (dram_ras),
    .sdram_aref (sdram_aref),
    .en_q       (ctl_q.en),
    .cnt        (cnt_w)
);

// File: tb/mem_refresh_timer_tb.sv
module mem_refresh_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 60000;

    localparam int EV_REQ   = 0;
    localparam int EV_CAS   = 1;
    localparam int EV_RAS   = 2;
    localparam int EV_FALL  = 3;
    localparam int EV_AREF  = 4;
    localparam int EV_AOFF  = 5;

    typedef struct {
        int    cyc;
        int    kind;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [10:0] cfg_count = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_hold = '0;
    logic [0:0]  cfg_setup = '0;
    logic        mem_sdram = 1'b0;
    logic        ref_gnt = 1'b0;
    logic        ref_req, dram_cas, dram_ras, sdram_aref;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    ev_t  exp_q[$];

    mem_refresh_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_count  (cfg_count),
        .cfg_en     (cfg_en),
        .cfg_hold   (cfg_hold),
        .cfg_setup  (cfg_setup),
        .mem_sdram  (mem_sdram),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .dram_cas   (dram_cas),
        .dram_ras   (dram_ras),
        .sdram_aref (sdram_aref)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(int c, int k, string tag);
        ev_t e;
        e.cyc = c; e.kind = k; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: detect output events and compare them with the scoreboard.
    logic p_req = 1'b0, p_cas = 1'b0, p_ras = 1'b0, p_aref = 1'b0;

    task automatic observe(int kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event", kind, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind, e.tag, kind, e.kind);
            check(e.cyc == cyc, e.tag, cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_req && !p_req)     observe(EV_REQ);
            if (dram_cas && !p_cas)    observe(EV_CAS);
            if (dram_ras && !p_ras)    observe(EV_RAS);
            if (!dram_cas && p_cas)    observe(EV_FALL);
            if (sdram_aref && !p_aref) observe(EV_AREF);
            if (!sdram_aref && p_aref) observe(EV_AOFF);
        end
        p_req  = ref_req;
        p_cas  = dram_cas;
        p_ras  = dram_ras;
        p_aref = sdram_aref;
    end

    // Driver: called right after a negedge; the write lands on the next edge.
    task automatic do_write(int c, bit en, int h, int s, output int edge_cyc);
        cfg_count = 11'(c);
        cfg_en    = en;
        cfg_hold  = 3'(h);
        cfg_setup = 1'(s);
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        edge_cyc  = cyc;
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drained(string tag);
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        check(ref_req == 1'b0, tag, int'(ref_req), 0);
    endtask

    task automatic run_periodic(int c, int s, int h, bit sd, int n, string tag);
        int e, p, sl, hl, base, last, e2;
        p  = 2049 - c;
        sl = s + 1;
        hl = ((h > 4) ? 4 : h) + 1;
        mem_sdram = sd;
        ref_gnt   = 1'b1;
        do_write(c, 1'b1, h, s, e);
        last = e;
        for (int k = 1; k <= n; k++) begin
            base = e + k * p;
            push(base, EV_REQ, tag);
            if (sd) begin
                push(base + 1, EV_AREF, tag);
                push(base + 2, EV_AOFF, tag);
                last = base + 2;
            end else begin
                push(base + 1, EV_CAS, tag);
                push(base + 1 + sl, EV_RAS, tag);
                push(base + 1 + sl + hl, EV_FALL, tag);
                last = base + 1 + sl + hl;
            end
        end
        wait_until(last);
        do_write(c, 1'b0, h, s, e2);
        ref_gnt = 1'b0;
        drained(tag);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int e, e2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ref_req == 1'b0,    "R1 req", int'(ref_req), 0);
        check(dram_cas == 1'b0,   "R1 cas", int'(dram_cas), 0);
        check(dram_ras == 1'b0,   "R1 ras", int'(dram_ras), 0);
        check(sdram_aref == 1'b0, "R1 aref", int'(sdram_aref), 0);
        repeat (2100) @(negedge clk);
        check(ref_req == 1'b0, "R1 no request before write", int'(ref_req), 0);

        // R2 R7 R8: DRAM, setup 1, hold 2
        run_periodic(2040, 0, 1, 1'b0, 3, "R2 R7 R8 dram s1 h2");
        // R7 R8: DRAM, setup 2, hold 5
        run_periodic(2030, 1, 4, 1'b0, 2, "R7 R8 dram s2 h5");
        // R10: SDRAM auto-refresh pulses
        run_periodic(2044, 0, 0, 1'b1, 3, "R10 sdram pulse");
        // R2 R9: count 0 gives longest interval, hold code 7 clamps to 5
        run_periodic(0, 1, 7, 1'b0, 1, "R2 R9 longest interval clamp");

        // R2: count 2047 gives shortest interval (no grant)
        mem_sdram = 1'b0;
        ref_gnt   = 1'b0;
        do_write(2047, 1'b1, 0, 0, e);
        push(e + 2, EV_REQ, "R2 shortest interval");
        wait_until(e + 6);
        check(ref_req == 1'b1, "R5 req held without grant", int'(ref_req), 1);
        do_write(2047, 1'b0, 0, 0, e2);
        check(ref_req == 1'b0, "R4 disable drops pending req", int'(ref_req), 0);
        drained("R4 quiet after disable");

        // R3: rewrite mid-interval restarts from the new value
        ref_gnt = 1'b1;
        do_write(2040, 1'b1, 0, 0, e);
        wait_until(e + 4);
        do_write(2044, 1'b1, 0, 0, e2);
        push(e2 + 5, EV_REQ, "R3 reload on rewrite");
        push(e2 + 6, EV_CAS, "R3 reload on rewrite");
        push(e2 + 7, EV_RAS, "R3 reload on rewrite");
        push(e2 + 8, EV_FALL, "R3 reload on rewrite");
        wait_until(e2 + 8);
        do_write(2044, 1'b0, 0, 0, e);
        ref_gnt = 1'b0;
        drained("R3 quiet after disable");

        // R5 R6: delayed grant, counter keeps schedule
        do_write(2030, 1'b1, 0, 0, e);
        push(e + 19, EV_REQ, "R5 delayed grant req");
        wait_until(e + 25);
        check(ref_req == 1'b1, "R5 req waits for grant", int'(ref_req), 1);
        check(dram_cas == 1'b0, "R5 no strobe before grant", int'(dram_cas), 0);
        ref_gnt = 1'b1;
        push(e + 26, EV_CAS, "R5 strobe after grant");
        push(e + 27, EV_RAS, "R5 strobe after grant");
        push(e + 28, EV_FALL, "R5 strobe after grant");
        push(e + 38, EV_REQ, "R6 schedule kept");
        @(negedge clk);
        ref_gnt = 1'b0;
        check(ref_req == 1'b0, "R5 req drops after grant", int'(ref_req), 0);
        wait_until(e + 40);
        check(ref_req == 1'b1, "R6 next req pending", int'(ref_req), 1);
        do_write(2030, 1'b0, 0, 0, e2);
        check(ref_req == 1'b0, "R4 disable clears req", int'(ref_req), 0);
        drained("R4 R6 quiet after disable");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule